// File: doc/BRIEF.md
# Interruptible Memory Block Copy Engine

This block is a sequencer that moves a run of bytes from a source region to a destination region through a single memory port, issuing at most one access per clock. A caller loads a 32-bit source pointer, a 32-bit destination pointer and a 16-bit byte count, selects either the interruptible or the atomic variant, and pulses `start`. The engine first reads the source address and then the destination address without using the data. After that it alternates between a read of the source byte and a write of that byte to the destination.

In the interruptible variant the engine checks for a pending request at the end of every byte write. A request is either a non-maskable request, or a maskable request whose mask bit is clear. If a request is pending, the engine stops at that byte boundary and pulses `suspended`. At that point the live pointers and the count describe exactly the bytes still to be copied. The caller resumes by issuing the copy again from those values whenever the count is non-zero. In the atomic variant every request is ignored until the copy finishes.

The state machine has these states:
- IDLE: waits for `start`.
- LOAD: one cycle to latch the operands.
- PRE_SRC: dummy read of the source address.
- PRE_DST: dummy read of the destination address.
- RD: reads one source byte.
- WR: writes that byte to the destination.
- FIN: pulses `done` for one cycle.
- HALT: pulses `suspended` for one cycle.

The transitions are:
- IDLE→LOAD on `start`.
- LOAD→PRE_SRC.
- PRE_SRC→PRE_DST.
- PRE_DST→FIN when the count is zero, otherwise PRE_DST→RD.
- RD→WR.
- WR→FIN on the last byte.
- WR→HALT when a request is accepted, otherwise WR→RD.
- FIN→IDLE and HALT→IDLE.

Top module: `blkcopy_engine`

## Requirements
- R1: A `start` pulse seen in IDLE latches `src_in`, `dst_in`, `cnt_in` and `atomic_mode`, and these values appear on `src_ptr`, `dst_ptr` and `count` from the next cycle. A `start` pulse seen in any other state is ignored, and the run in progress is unchanged.
- R2: The first access of every invocation is a read (`mem_rd`=1) at the source pointer. The second access is a read at the destination pointer.
- R3: Each byte is read at `src_ptr` in one cycle. In the next cycle the value returned on `mem_rdata` is written (`mem_wr`=1, `mem_wdata`) at `dst_ptr`. An invocation that copies n bytes makes n+2 reads and n writes, which is 2(n+1) accesses. `mem_rd` and `mem_wr` are never high together.
- R4: `done` is high in the (4+2n)-th cycle after the edge that samples `start`, and `count` reads 0 then.
- R5: On every byte write, both `src_ptr` and `dst_ptr` increase by one and `count` decreases by one.
- R6: In interruptible mode (`atomic_mode`=0), a request pending in a write cycle suspends the run. A request is `nmi`=1, or `irq`=1 with `irq_mask`=0. The run is suspended only if bytes remain after that write. `suspended` is then high in the next cycle, with the pointers on the next byte and `count` giving the bytes left. `nmi` ignores `irq_mask`. A request during the last byte's write does not suspend.
- R7: `irq` has no effect while `irq_mask`=1.
- R8: With `atomic_mode`=1, neither `irq` nor `nmi` suspends the run, and `done` arrives at 4+2n cycles.
- R9: A count of 0 gives `done` in cycle 4 after the two dummy reads, with no write and unchanged pointers.
- R10: `done` and `suspended` are single-cycle pulses that are never high together, and the engine returns to IDLE after either one.
- R11: Re-issuing a suspended copy from `src_ptr`, `dst_ptr` and `count` completes the remaining bytes. The result is the same destination contents as an uninterrupted copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy (accepted in IDLE only) |
| src_in | input | 32 | Source start address |
| dst_in | input | 32 | Destination start address |
| cnt_in | input | 16 | Number of bytes to copy |
| atomic_mode | input | 1 | 1 = atomic copy, 0 = interruptible copy |
| irq | input | 1 | Maskable interrupt request |
| irq_mask | input | 1 | 1 masks `irq` |
| nmi | input | 1 | Non-maskable interrupt request |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| src_ptr | output | 32 | Live source pointer |
| dst_ptr | output | 32 | Live destination pointer |
| count | output | 16 | Live remaining byte count |
| done | output | 1 | Copy complete pulse |
| suspended | output | 1 | Copy suspended pulse; re-issue to resume |

## Verification
The copy is exercised with these request patterns:
- **A plain five-byte run.** This fixes the access order and the 4+2n timing.
- **A zero-byte run.** This separates the dummy-read overhead from the data phase.
- **A masked request.** This must leave timing untouched.
- **An unmasked request and a non-maskable request.** These must stop after exactly one byte, with the non-maskable request overriding the mask.
- **Both requests in atomic mode.** This must not stop the run.

The non-maskable case is held across the resumed run. That separates "suspend at every boundary" from "suspend only while bytes remain". A high source address checks that pointers carry all 32 bits. A `start` pulse sent in mid-run checks that busy starts are dropped. A scoreboard of expected addresses and data confirms that a suspended copy and its resumption together write the same bytes as an uninterrupted one.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PRE_SRC,
        ST_PRE_DST,
        ST_RD,
        ST_WR,
        ST_FIN,
        ST_HALT
    } cp_state_t;
endpackage

// File: rtl/blkcopy_ctx.sv
module blkcopy_ctx #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            src_q <= src_in;
            dst_q <= dst_in;
            cnt_q <= cnt_in;
        end else if (step) begin
            src_q <= src_q + AW'(1);
            dst_q <= dst_q + AW'(1);
            cnt_q <= cnt_q - CW'(1);
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (src_q == $past(src_in) && dst_q == $past(dst_in) && cnt_q == $past(cnt_in))); // R1
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (src_q == $past(src_q) + AW'(1) && dst_q == $past(dst_q) + AW'(1)
                            && cnt_q == $past(cnt_q) - CW'(1))); // R5
endmodule

// File: rtl/blkcopy_irq_gate.sv
module blkcopy_irq_gate (
    input  logic interruptible,
    input  logic irq,
    input  logic irq_mask,
    input  logic nmi,
    output logic take
);
    logic maskable_live;

    always_comb begin
        maskable_live = irq & ~irq_mask;
        take          = interruptible & (nmi | maskable_live);
    end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          atomic_mode,
    input  logic          irq,
    input  logic          irq_mask,
    input  logic          nmi,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] count,
    output logic          done,
    output logic          suspended
);
    localparam logic [CW-1:0] LAST_ONE = CW'(1);

    cp_state_t state, state_nx;
    logic      atomic_q;
    logic      take_req;
    logic      ld_ctx;
    logic      step_ctx;

    // operand / live context registers
    blkcopy_ctx #(.AW(AW), .CW(CW)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ld_ctx),
        .step   (step_ctx),
        .src_in (src_in),
        .dst_in (dst_in),
        .cnt_in (cnt_in),
        .src_q  (src_ptr),
        .dst_q  (dst_ptr),
        .cnt_q  (count)
    );

    blkcopy_irq_gate u_gate (
        .interruptible (~atomic_q),
        .irq           (irq),
        .irq_mask      (irq_mask),
        .nmi           (nmi),
        .take          (take_req)
    );

    // state register and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            atomic_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (ld_ctx) atomic_q <= atomic_mode;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_LOAD;
            ST_LOAD:    state_nx = ST_PRE_SRC;
            ST_PRE_SRC: state_nx = ST_PRE_DST;
            ST_PRE_DST: state_nx = (count == '0) ? ST_FIN : ST_RD;
            ST_RD:      state_nx = ST_WR;
            ST_WR: begin
                if (count == LAST_ONE) state_nx = ST_FIN;
                else if (take_req)     state_nx = ST_HALT;
                else                   state_nx = ST_RD;
            end
            ST_FIN:     state_nx = ST_IDLE;
            ST_HALT:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ld_ctx    = (state == ST_IDLE) && start;
        step_ctx  = (state == ST_WR);
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        suspended = 1'b0;
        unique case (state)
            ST_PRE_SRC, ST_RD: begin
                mem_rd   = 1'b1;
                mem_addr = src_ptr;
            end
            ST_PRE_DST: begin
                mem_rd   = 1'b1;
                mem_addr = dst_ptr;
            end
            ST_WR: begin
                mem_wr    = 1'b1;
                mem_addr  = dst_ptr;
                mem_wdata = mem_rdata;
            end
            ST_FIN:  done      = 1'b1;
            ST_HALT: suspended = 1'b1;
            default: ;
        endcase
    end

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R3
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd)); // R3
    AST_DUMMY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE_DST) |-> ($past(state) == ST_PRE_SRC && mem_addr == dst_ptr)); // R2
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && suspended)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_SUSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> !suspended); // R10
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == '0)); // R4
    AST_SUSP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (count != '0)); // R6
    AST_SUSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> $past(nmi || (irq && !irq_mask))); // R7
    AST_ATOMIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !atomic_q); // R8
endmodule

// File: tb/sim_blkcopy_engine.sv
`timescale 1ns/1ps
module sim_blkcopy_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_in = '0, dst_in = '0;
    logic [15:0] cnt_in = '0;
    logic        atomic_mode = 1'b0, irq = 1'b0, irq_mask = 1'b0, nmi = 1'b0;
    logic        mem_rd, mem_wr, done, suspended;
    logic [31:0] mem_addr, src_ptr, dst_ptr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] count;

    int n_chk = 0, n_fail = 0;
    logic [7:0]  mem [0:1023];
    logic [31:0] exp_a[$];
    logic [7:0]  exp_d[$];
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_a0 = '0, rd_a1 = '0;

    always #10 clk = ~clk; // 50 MHz

    blkcopy_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_in(src_in), .dst_in(dst_in),
        .cnt_in(cnt_in), .atomic_mode(atomic_mode), .irq(irq), .irq_mask(irq_mask),
        .nmi(nmi), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_ptr(src_ptr),
        .dst_ptr(dst_ptr), .count(count), .done(done), .suspended(suspended)
    );

    // memory model: read data returned the cycle after the read
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            if (rd_cnt == 0) rd_a0 = mem_addr;
            if (rd_cnt == 1) rd_a1 = mem_addr;
            rd_cnt++;
        end
        if (rst_n && mem_wr) begin
            wr_cnt++;
            if (exp_a.size() == 0) chk(1'b0, "R3 unexpected write", mem_addr, 0);
            else begin
                logic [31:0] ea;
                logic [7:0]  ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                chk(mem_addr == ea, "R3 write address", mem_addr, ea);
                chk(mem_wdata == ed, "R3 write data", mem_wdata, ed);
            end
        end
    end

    // driver: pushes expected writes, issues the copy, counts cycles
    task automatic run_copy(input logic [31:0] s, input logic [31:0] d, input int n,
                            input bit atom, input bit push, input bit poke,
                            output int cyc, output bit got_done);
        if (push) begin
            for (int i = 0; i < n; i++) begin
                logic [31:0] a;
                a = s + 32'(i);
                exp_a.push_back(d + 32'(i));
                exp_d.push_back(mem[a[9:0]]);
            end
        end
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        src_in = s; dst_in = d; cnt_in = 16'(n); atomic_mode = atom; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!(done || suspended) && cyc < 150000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; src_in = 32'h0000_0377; cnt_in = 16'd9;
            end else start = 1'b0;
        end
        got_done = done;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int  cyc;
        bit  gd;
        logic [31:0] s, d;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        chk(!done && !suspended && !mem_rd && !mem_wr, "R10 reset outputs idle",
            {done, suspended, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // plain run, n=5
        s = 32'h100; d = 32'h200;
        run_copy(s, d, 5, 1'b0, 1'b1, 1'b0, cyc, gd);
        chk(gd, "R4 done reached", gd, 1);
        chk(cyc == 14, "R4 cycles 4+2n", cyc, 14);
        chk(rd_cnt == 7 && wr_cnt == 5, "R3 access counts", rd_cnt * 100 + wr_cnt, 705);
        chk(rd_a0 == s, "R2 first read at source", rd_a0, s);
        chk(rd_a1 == d, "R2 second read at destination", rd_a1, d);
        chk(src_ptr == s + 5 && dst_ptr == d + 5, "R5 pointers advanced", src_ptr, s + 5);
        chk(count == 0, "R5 count drained", count, 0);
        @(negedge clk);
        chk(!done && !suspended, "R10 done single cycle", done, 0);

        // zero count
        s = 32'h150; d = 32'h250;
        run_copy(s, d, 0, 1'b0, 1'b1, 1'b0, cyc, gd);
        chk(gd && cyc == 4, "R9 zero count done at cycle 4", cyc, 4);
        chk(wr_cnt == 0 && rd_cnt == 2, "R9 only dummy reads", rd_cnt * 100 + wr_cnt, 200);
        chk(src_ptr == s && dst_ptr == d, "R9 pointers unchanged", src_ptr, s);
        @(negedge clk);

        // masked irq ignored
        irq = 1'b1; irq_mask = 1'b1;
        run_copy(32'h108, 32'h208, 3, 1'b0, 1'b1, 1'b0, cyc, gd);
        chk(gd && cyc == 10, "R7 masked irq no effect", cyc, 10);
        @(negedge clk);

        // unmasked irq suspends, then resume
        irq_mask = 1'b0;
        s = 32'h120; d = 32'h300;
        run_copy(s, d, 3, 1'b0, 1'b1, 1'b0, cyc, gd);
        chk(!gd && suspended && cyc == 6, "R6 irq suspends after one byte", cyc, 6);
        chk(count == 2, "R6 remaining count", count, 2);
        chk(src_ptr == s + 1 && dst_ptr == d + 1, "R6 next-byte pointers", dst_ptr, d + 1);
        @(negedge clk);
        chk(!suspended && !done, "R10 suspended single cycle", suspended, 0);
        irq = 1'b0;
        run_copy(src_ptr, dst_ptr, int'(count), 1'b0, 1'b0, 1'b0, cyc, gd);
        chk(gd && cyc == 8, "R11 resume completes", cyc, 8);
        chk(src_ptr == s + 3 && count == 0, "R11 final pointer", src_ptr, s + 3);
        @(negedge clk);

        // atomic ignores nmi and irq
        irq = 1'b1; nmi = 1'b1;
        run_copy(32'h8000_0140, 32'h240, 4, 1'b1, 1'b1, 1'b0, cyc, gd);
        chk(gd && cyc == 12, "R8 atomic ignores requests", cyc, 12);
        chk(src_ptr == 32'h8000_0144, "R5 full-width pointer", src_ptr, 32'h8000_0144);
        @(negedge clk);

        // nmi overrides mask; last byte never suspended
        irq_mask = 1'b1;
        s = 32'h160; d = 32'h330;
        run_copy(s, d, 2, 1'b0, 1'b1, 1'b0, cyc, gd);
        chk(!gd && cyc == 6 && count == 1, "R6 nmi suspends despite mask", cyc, 6);
        @(negedge clk);
        run_copy(src_ptr, dst_ptr, int'(count), 1'b0, 1'b0, 1'b0, cyc, gd);
        chk(gd && cyc == 6, "R6 last byte not suspended", cyc, 6);
        @(negedge clk);
        nmi = 1'b0; irq = 1'b0; irq_mask = 1'b0;

        // start while busy is ignored
        s = 32'h180; d = 32'h380;
        run_copy(s, d, 4, 1'b0, 1'b1, 1'b1, cyc, gd);
        start = 1'b0;
        chk(gd && cyc == 12, "R1 busy start ignored timing", cyc, 12);
        chk(src_ptr == s + 4 && count == 0, "R1 busy start ignored pointers", src_ptr, s + 4);
        @(negedge clk);
        chk(!done && !suspended && !mem_rd, "R1 no second run", mem_rd, 0);

        repeat (2) @(negedge clk);
        chk(exp_a.size() == 0, "R3 all expected writes seen", exp_a.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule